// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects level-sensitive interrupt lines in groups of 32 called banks and turns them into three request lines for a processor: a normal interrupt request, a fast interrupt request and an endpoint interrupt. Each bank has one raw cause view, which always shows the live state of its 32 inputs. It also has three independent enable planes, one for each output. An output rises when any input is high and enabled in that output's plane, in any bank. Sources are never latched: software clears a request by removing its cause at the source or by disabling it.

Software reaches each bank through a register window of 32 bytes. It reads the cause view, writes and reads the three enable planes, and reads a status word. The status word reports the highest-numbered source that is both pending and enabled for the normal interrupt. The handler can then serve sources from the top bit down. The number of banks is a parameter.

Top module: `lvl_intc_top`

## Requirements
- R1: After reset the three enable planes of every bank read 0, and `irq_o`, `fiq_o`, `endp_o` and `rvalid` are 0.
- R2: The cause register (window offset 0x00) reads the present level of the bank's 32 inputs. A source that goes low reads 0 on the next read, with no latching.
- R3: Offsets 0x04 (normal enable), 0x08 (fast enable) and 0x0C (endpoint enable) store the written word and read it back. A 1 enables the source in that bit position.
- R4: Writes to the cause offset 0x00 and to the status offset 0x10 change no state and no output.
- R5: `irq_o` equals, one clock later, the OR over all banks and bits of (inputs AND normal enable).
- R6: `fiq_o` equals, one clock later, the OR over all banks and bits of (inputs AND fast enable), independent of the other planes.
- R7: `endp_o` equals, one clock later, the OR over all banks and bits of (inputs AND endpoint enable), independent of the other planes.
- R8: The status word at offset 0x10 has bit 31 set when (inputs AND normal enable) is nonzero. Bits 4:0 then hold the index of its highest set bit. All other bits are 0, and the whole word is 0 when nothing is pending.
- R9: Bank n owns inputs `src_i[32n+31:32n]`, and its window starts at byte address 32·n (address bits 7:5 select the bank).
- R10: `rdata` and `rvalid` update one clock after `rd_en`. Reads of a nonexistent bank, of offsets 0x14 to 0x1C, or of an address with bits 1:0 nonzero return 0. Writes to any such address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_BANKS*32 | Level-sensitive interrupt inputs, bank n at bits 32n+31:32n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one clock after rd_en |
| irq_o | output | 1 | Combined normal interrupt request |
| fiq_o | output | 1 | Combined fast interrupt request |
| endp_o | output | 1 | Combined endpoint interrupt |

## Verification
The bound checker watches the read timing, the three outputs and the status word on every cycle. On each cycle it confirms that `rvalid` follows `rd_en` by exactly one clock. It confirms that no output and no status valid flag can be high after a cycle in which every input was low, and that a cause read taken while all inputs were low returns zero. Only the bench scenarios can show the positive behaviour. That covers the three planes acting independently on one shared cause view, the exact highest-index values, the bank-to-address mapping, and the rule that writes to the cause and status offsets and to misaligned or unmapped addresses leave the enable planes unchanged.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned INTC_W = 32;
    localparam int unsigned IDX_W  = $clog2(INTC_W);
    localparam int unsigned WIN_W  = 5;

    typedef enum logic [2:0] {
        SEL_CAUSE  = 3'd0,
        SEL_IRQEN  = 3'd1,
        SEL_FIQEN  = 3'd2,
        SEL_ENDEN  = 3'd3,
        SEL_STATUS = 3'd4,
        SEL_RSV5   = 3'd5,
        SEL_RSV6   = 3'd6,
        SEL_RSV7   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/intc_hi_idx.sv
module intc_hi_idx #(
    parameter int unsigned W = 32,
    localparam int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = 0; i < int'(W); i++) begin
            if (vec[i]) begin
                idx   = IW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  reg_sel_e          sel,
    input  logic [INTC_W-1:0] wdata,
    input  logic [INTC_W-1:0] src,
    output logic [INTC_W-1:0] rd_word,
    output logic              irq_any,
    output logic              fiq_any,
    output logic              endp_any
);
    logic [INTC_W-1:0] irq_en, fiq_en, endp_en;
    logic [INTC_W-1:0] pend_irq;
    logic [IDX_W-1:0]  top_idx;
    logic              top_found;
    logic [INTC_W-1:0] status_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en  <= '0;
            fiq_en  <= '0;
            endp_en <= '0;
        end else if (wr_stb) begin
            unique case (sel)
                SEL_IRQEN: irq_en  <= wdata;
                SEL_FIQEN: fiq_en  <= wdata;
                SEL_ENDEN: endp_en <= wdata;
                default:   ;
            endcase
        end
    end

    assign pend_irq = src & irq_en;
    assign irq_any  = |pend_irq;
    assign fiq_any  = |(src & fiq_en);
    assign endp_any = |(src & endp_en);

    intc_hi_idx #(.W(INTC_W)) hi_i (
        .vec   (pend_irq),
        .idx   (top_idx),
        .found (top_found)
    );

    always_comb begin
        status_word                = '0;
        status_word[INTC_W-1]      = top_found;
        status_word[IDX_W-1:0]     = top_idx;
    end

    always_comb begin
        unique case (sel)
            SEL_CAUSE:  rd_word = src;
            SEL_IRQEN:  rd_word = irq_en;
            SEL_FIQEN:  rd_word = fiq_en;
            SEL_ENDEN:  rd_word = endp_en;
            SEL_STATUS: rd_word = status_word;
            default:    rd_word = '0;
        endcase
    end
endmodule

// File: rtl/lvl_intc_top.sv
module lvl_intc_top
    import intc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8,
    localparam int unsigned SRC_W    = NUM_BANKS * INTC_W,
    localparam int unsigned BANK_W   = ADDR_W - WIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  src_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [INTC_W-1:0] wdata,
    output logic [INTC_W-1:0] rdata,
    output logic              rvalid,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              endp_o
);
    logic              aligned;
    logic [BANK_W-1:0] bank_field;
    reg_sel_e          sel;
    logic [INTC_W-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] irq_vec, fiq_vec, endp_vec;
    logic [INTC_W-1:0] rd_mux;

    assign aligned    = (addr[1:0] == 2'b00);
    assign bank_field = addr[ADDR_W-1:WIN_W];
    assign sel        = reg_sel_e'(addr[WIN_W-1:2]);

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        logic hit;
        assign hit = aligned && (int'(bank_field) == b);
        intc_bank bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (wr_en && hit),
            .sel      (sel),
            .wdata    (wdata),
            .src      (src_i[b*INTC_W +: INTC_W]),
            .rd_word  (bank_rd[b]),
            .irq_any  (irq_vec[b]),
            .fiq_any  (fiq_vec[b]),
            .endp_any (endp_vec[b])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (aligned && (int'(bank_field) == b)) rd_mux = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o  <= 1'b0;
            fiq_o  <= 1'b0;
            endp_o <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            irq_o  <= |irq_vec;
            fiq_o  <= |fiq_vec;
            endp_o <= |endp_vec;
            rvalid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
    parameter int unsigned NUM_BANKS = 2,
    parameter int unsigned ADDR_W    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_BANKS*32-1:0] src_i,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [31:0]             rdata,
    input logic                    rvalid,
    input logic                    irq_o,
    input logic                    fiq_o,
    input logic                    endp_o
);
    a_r10_rvalid_set: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    a_r10_rvalid_clr: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    a_r5_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> !irq_o);
    a_r6_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> !fiq_o);
    a_r7_endp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |=> !endp_o);
    a_r2_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0 && src_i == '0) |=> (rdata == 32'h0));
    a_r8_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr[4:0] == 5'h10 && src_i == '0) |=> !rdata[31]);
endmodule

bind lvl_intc_top lvl_intc_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .rd_en  (rd_en),
    .addr   (addr),
    .rdata  (rdata),
    .rvalid (rvalid),
    .irq_o  (irq_o),
    .fiq_o  (fiq_o),
    .endp_o (endp_o)
);

// File: tb/lvl_intc_top_tb_top.sv
`timescale 1ns/1ps
module lvl_intc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid, irq_o, fiq_o, endp_o;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lvl_intc_top #(.NUM_BANKS(2), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .irq_o(irq_o), .fiq_o(fiq_o), .endp_o(endp_o)
    );

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] ien;
        logic [31:0] fen;
        logic [31:0] een;
        logic [2:0]  outs;
        logic [31:0] stat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 3'b100, 32'h8000_0000},
        '{32'h8000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0000, 3'b110, 32'h8000_001F},
        '{32'h0000_0F00, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0100, 3'b001, 32'h0000_0000},
        '{32'h0012_0000, 32'h0003_0000, 32'h0010_0000, 32'h0000_0000, 3'b110, 32'h8000_0011},
        '{32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0000_0001, 32'hFFFF_0000, 3'b011, 32'h0000_0000},
        '{32'hFFFF_FFFF, 32'h0000_4000, 32'h0000_0000, 32'h0000_0000, 3'b100, 32'h8000_000E}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R10 rvalid after read", {31'b0, rvalid}, 32'h1);
        v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {28'b0, irq_o, fiq_o, endp_o, rvalid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 outputs after reset", {28'b0, irq_o, fiq_o, endp_o, rvalid}, 32'h0);
        for (int a = 4; a <= 12; a += 4) begin
            rd(8'(a), v);        chk("R1 bank0 enable clear", v, 32'h0);
            rd(8'(32 + a), v);   chk("R1 bank1 enable clear", v, 32'h0);
        end

        // table walk over bank 0: R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(8'h04, TBL[i].ien);
            wr(8'h08, TBL[i].fen);
            wr(8'h0C, TBL[i].een);
            src_i[31:0] = TBL[i].src;
            @(negedge clk);
            chk("R5 irq_o", {31'b0, irq_o}, {31'b0, TBL[i].outs[2]});
            chk("R6 fiq_o", {31'b0, fiq_o}, {31'b0, TBL[i].outs[1]});
            chk("R7 endp_o", {31'b0, endp_o}, {31'b0, TBL[i].outs[0]});
            rd(8'h10, v); chk("R8 status", v, TBL[i].stat);
            rd(8'h08, v); chk("R3 fast enable readback", v, TBL[i].fen);
        end

        // R2: live cause, no latching
        src_i[31:0] = 32'h1234_5678;
        rd(8'h00, v); chk("R2 cause live", v, 32'h1234_5678);
        src_i[31:0] = 32'h0;
        rd(8'h00, v); chk("R2 cause after drop", v, 32'h0);

        // R5 latency: output changes one clock after the input
        wr(8'h04, 32'h0000_0002);
        src_i[31:0] = 32'h0000_0002;
        #1 chk("R5 irq not yet", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R5 irq one clock later", {31'b0, irq_o}, 32'h1);
        src_i[31:0] = 32'h0;
        @(negedge clk);
        chk("R2 irq falls with level", {31'b0, irq_o}, 32'h0);

        // R4: writes to cause and status change nothing
        wr(8'h04, 32'h0000_00F0);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R4 cause unchanged", v, 32'h0);
        rd(8'h10, v); chk("R4 status unchanged", v, 32'h0);
        rd(8'h04, v); chk("R4 enable unchanged", v, 32'h0000_00F0);
        chk("R4 no output", {29'b0, irq_o, fiq_o, endp_o}, 32'h0);

        // R9: bank 1 mapping
        wr(8'h04, 32'h0);
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0);
        wr(8'h24, 32'h0000_0008);
        src_i = {32'h0000_0008, 32'h0000_0008};
        @(negedge clk);
        chk("R9 bank1 drives irq", {31'b0, irq_o}, 32'h1);
        rd(8'h30, v); chk("R9 bank1 status", v, 32'h8000_0003);
        rd(8'h10, v); chk("R9 bank0 status idle", v, 32'h0);
        rd(8'h20, v); chk("R9 bank1 cause", v, 32'h0000_0008);
        src_i = '0;

        // R10: unmapped and misaligned
        rd(8'h40, v); chk("R10 missing bank reads 0", v, 32'h0);
        rd(8'h14, v); chk("R10 reserved offset reads 0", v, 32'h0);
        rd(8'h25, v); chk("R10 misaligned read 0", v, 32'h0);
        wr(8'h25, 32'hFFFF_FFFF);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R10 misaligned write ignored", v, 32'h0000_0008);
        @(negedge clk);
        chk("R10 rvalid idle", {31'b0, rvalid}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule